// File: doc/BRIEF.md
# Memory Command Scheduler

This block sits at the front of a memory controller and decides, cycle by cycle, whether the next command sent toward the memory is a read or a write. Requests arrive on two independent valid/ready ports, one for reads and one for writes, and are held in two first-in first-out queues. One command is offered at a time on a single output port with a read/write flag. The memory side accepts it by raising its ready signal.

Which class is offered depends on one of four scheduling modes. The block enters a mode from the queue occupancies and from the age of waiting reads:
- **Read-first** is the default.
- **Write-drain** is entered when writes pile up. It has hysteresis, so it does not leave as soon as the count dips.
- **Interleave** alternates the two classes while both queues are well occupied.
- **Starvation recovery** pushes out reads that have waited too long.

The active mode is exported as a two-bit status. DRAM timing, bank state and data movement are outside this block.

Top module: `mem_cmd_sched`

## Requirements
- R1: After reset `mode_o` is 2'b00 (read-first), `cmd_valid` is 0, and both `rd_req_ready` and `wr_req_ready` are 1.
- R2: In read-first mode (`mode_o` = 2'b00), a pending read is offered ahead of any pending write. A write is offered only when the read queue is empty.
- R3: When the write count exceeds `HI_WM` and no read is starved, `mode_o` is 2'b01 (write-drain) and writes are offered (`cmd_is_wr` = 1).
- R4: Write-drain stays in force while the write count is above `LO_WM`, even after it drops to or below `HI_WM`. It ends once the count is at or below `LO_WM`.
- R5: When both queue counts exceed `MIX_MIN`, with no starvation and no write-drain, `mode_o` is 2'b10 (interleave) and each accepted command is of the opposite class to the one before.
- R6: When any queued read has an age of at least `STARVE_LIM`, `mode_o` is 2'b11 and the oldest read is offered. This takes precedence over write-drain. Once no read is starved, the mode falls back to whichever mode would otherwise apply.
- R7: A read's age is 0 when it is queued and rises by one each cycle that it stays queued. It saturates at 2^`AGE_W`-1 rather than wrapping, so a starved read stays starved.
- R8: A command is accepted only in a cycle where `cmd_valid` and `cmd_ready` are both 1, and at most one is accepted per cycle. While `cmd_ready` is 0, `cmd_valid` stays 1 and no queue entry is consumed.
- R9: Each queue keeps its arrival order and holds `DEPTH` entries. When a queue is full its ready signal is 0 and a request presented then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read queue can take a request |
| rd_req_addr | input | ADDR_W | Read request address |
| wr_req_valid | input | 1 | Write request present |
| wr_req_ready | output | 1 | Write queue can take a request |
| wr_req_addr | input | ADDR_W | Write request address |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Memory side accepts the offered command |
| cmd_is_wr | output | 1 | Offered command is a write (1) or a read (0) |
| cmd_addr | output | ADDR_W | Address of the offered command |
| mode_o | output | 2 | Scheduling mode: 00 read-first, 01 write-drain, 10 interleave, 11 starvation |

## Verification
The assertions assume that reset is held for at least one clock before operation starts. They also assume that the thresholds are ordered with `LO_WM` below `HI_WM` and `STARVE_LIM` within the age range. The stimulus keeps the requests to at most one per port per cycle. It changes inputs only at falling edges and uses parameter values that meet these orderings. When it fills a queue, it does so only while the output is stalled, so that the occupancy seen at each check is exactly what the test pushed.

// File: rtl/mem_cmd_sched_pkg.sv
package mem_cmd_sched_pkg;
  typedef enum logic [1:0] {
    MODE_RDFIRST = 2'b00,
    MODE_WRDRAIN = 2'b01,
    MODE_MIXED   = 2'b10,
    MODE_STARVE  = 2'b11
  } sched_mode_e;
endpackage

// File: rtl/sched_req_queue.sv
module sched_req_queue #(
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 16,
  parameter bit AGE_EN     = 1'b0,
  parameter int AGE_W      = 5,
  parameter int STARVE_LIM = 10,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int CNT_W     = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              starved
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              do_push, do_pop;

  assign push_ready = (cnt != FULL_C);
  assign do_push    = push_valid & push_ready;
  assign do_pop     = pop & (cnt != '0);
  assign count      = cnt;
  assign head_data  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  generate
    if (AGE_EN) begin : g_age
      localparam logic [AGE_W-1:0] LIM_C = AGE_W'(STARVE_LIM);
      localparam logic [AGE_W-1:0] MAX_C = '1;
      logic [AGE_W-1:0] age [DEPTH];
      logic [DEPTH-1:0] slot_old;
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PTR_W-1:0] offs;
        logic             live;
        assign offs        = PTR_W'(g) - rd_ptr;
        assign live        = CNT_W'(offs) < cnt;
        assign slot_old[g] = live && (age[g] >= LIM_C);
        always_ff @(posedge clk) begin
          if (rst) begin
            age[g] <= '0;
          end else if (do_push && (wr_ptr == PTR_W'(g))) begin
            age[g] <= '0;
          end else if (live && !(do_pop && (rd_ptr == PTR_W'(g))) && (age[g] != MAX_C)) begin
            age[g] <= age[g] + 1'b1;
          end
        end
      end
      assign starved = |slot_old;
    end else begin : g_noage
      assign starved = 1'b0;
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_C); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready && !pop) |=> (cnt == $past(cnt))); // R9
endmodule

// File: rtl/sched_mode_ctrl.sv
module sched_mode_ctrl
  import mem_cmd_sched_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int HI_WM   = 5,
  parameter int LO_WM   = 2,
  parameter int MIX_MIN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             rd_starved,
  input  logic             issue,
  output sched_mode_e      mode,
  output logic             sel_wr
);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(HI_WM);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LO_WM);
  localparam logic [CNT_W-1:0] MIX_C = CNT_W'(MIX_MIN);

  logic wp_hold, last_wr, wp_now, mixed_ok;

  assign wp_now   = (wr_cnt > HI_C) | (wp_hold & (wr_cnt > LO_C));
  assign mixed_ok = (rd_cnt > MIX_C) & (wr_cnt > MIX_C);

  always_comb begin
    if (rd_starved)    mode = MODE_STARVE;
    else if (wp_now)   mode = MODE_WRDRAIN;
    else if (mixed_ok) mode = MODE_MIXED;
    else               mode = MODE_RDFIRST;
  end

  always_comb begin
    case (mode)
      MODE_STARVE:  sel_wr = 1'b0;
      MODE_WRDRAIN: sel_wr = 1'b1;
      MODE_MIXED:   sel_wr = ~last_wr;
      default:      sel_wr = (rd_cnt == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_hold <= 1'b0;
      last_wr <= 1'b0;
    end else begin
      wp_hold <= wp_now;
      if (issue) last_wr <= sel_wr;
    end
  end

  AST_WP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRDRAIN) |=> (rd_starved || (wr_cnt <= LO_C) || (mode == MODE_WRDRAIN))); // R4
  AST_MIX_ALT: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MIXED && issue) |=> ((mode != MODE_MIXED) || (sel_wr != $past(sel_wr)))); // R5
endmodule

// File: rtl/mem_cmd_sched.sv
module mem_cmd_sched
  import mem_cmd_sched_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 16,
  parameter int AGE_W      = 5,
  parameter int HI_WM      = 5,
  parameter int LO_WM      = 2,
  parameter int MIX_MIN    = 1,
  parameter int STARVE_LIM = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_addr,
  input  logic              wr_req_valid,
  output logic              wr_req_ready,
  input  logic [ADDR_W-1:0] wr_req_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_is_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        mode_o
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [CNT_W-1:0]  rd_cnt, wr_cnt;
  logic [ADDR_W-1:0] rd_head, wr_head;
  logic              rd_starved, wr_starved_unused;
  logic              issue, sel_wr;
  sched_mode_e       mode;

  assign cmd_valid = (rd_cnt != '0) | (wr_cnt != '0);
  assign issue     = cmd_valid & cmd_ready;
  assign cmd_is_wr = sel_wr;
  assign cmd_addr  = sel_wr ? wr_head : rd_head;
  assign mode_o    = mode;

  sched_req_queue #(
    .DEPTH(DEPTH), .DATA_W(ADDR_W), .AGE_EN(1'b1),
    .AGE_W(AGE_W), .STARVE_LIM(STARVE_LIM)
  ) rd_q_i (
    .clk(clk), .rst(rst),
    .push_valid(rd_req_valid), .push_ready(rd_req_ready), .push_data(rd_req_addr),
    .pop(issue & ~sel_wr), .head_data(rd_head), .count(rd_cnt), .starved(rd_starved)
  );

  sched_req_queue #(
    .DEPTH(DEPTH), .DATA_W(ADDR_W), .AGE_EN(1'b0),
    .AGE_W(AGE_W), .STARVE_LIM(STARVE_LIM)
  ) wr_q_i (
    .clk(clk), .rst(rst),
    .push_valid(wr_req_valid), .push_ready(wr_req_ready), .push_data(wr_req_addr),
    .pop(issue & sel_wr), .head_data(wr_head), .count(wr_cnt), .starved(wr_starved_unused)
  );

  sched_mode_ctrl #(
    .CNT_W(CNT_W), .HI_WM(HI_WM), .LO_WM(LO_WM), .MIX_MIN(MIX_MIN)
  ) mode_i (
    .clk(clk), .rst(rst), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
    .rd_starved(rd_starved), .issue(issue), .mode(mode), .sel_wr(sel_wr)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> cmd_valid); // R8
  AST_STARVE_READ: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STARVE) |-> (cmd_valid && !cmd_is_wr)); // R6
endmodule

// File: tb/mem_cmd_sched_tb_top.sv
`timescale 1ns/1ps
module mem_cmd_sched_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req_valid = 1'b0, wr_req_valid = 1'b0, cmd_ready = 1'b0;
  logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
  logic          rd_req_ready, wr_req_ready, cmd_valid, cmd_is_wr;
  logic [AW-1:0] cmd_addr;
  logic [1:0]    mode_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_cmd_sched #(
    .DEPTH(8), .ADDR_W(AW), .AGE_W(5), .HI_WM(5), .LO_WM(2),
    .MIX_MIN(1), .STARVE_LIM(10)
  ) dut_i (
    .clk(clk), .rst(rst),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_wr(cmd_is_wr),
    .cmd_addr(cmd_addr), .mode_o(mode_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_rd(input logic [AW-1:0] a);
    rd_req_valid = 1'b1; rd_req_addr = a;
    @(negedge clk);
    rd_req_valid = 1'b0;
  endtask

  task automatic push_wr(input logic [AW-1:0] a);
    wr_req_valid = 1'b1; wr_req_addr = a;
    @(negedge clk);
    wr_req_valid = 1'b0;
  endtask

  task automatic pulse;
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic drain;
    cmd_ready = 1'b1;
    while (cmd_valid) @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", {30'd0, mode_o}, 32'h0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'h0);
    chk("R1 rd_ready", {31'd0, rd_req_ready}, 32'h1);
    chk("R1 wr_ready", {31'd0, wr_req_ready}, 32'h1);
  endtask

  task automatic t_read_first;
    push_wr(16'h2001);
    push_rd(16'h1001);
    chk("R2 mode", {30'd0, mode_o}, 32'h0);
    chk("R2 read first", {31'd0, cmd_is_wr}, 32'h0);
    chk("R2 addr", {16'd0, cmd_addr}, 32'h1001);
    repeat (3) @(negedge clk);
    chk("R8 stall keeps valid", {31'd0, cmd_valid}, 32'h1);
    chk("R8 stall keeps addr", {16'd0, cmd_addr}, 32'h1001);
    pulse();
    chk("R2 write after reads", {31'd0, cmd_is_wr}, 32'h1);
    chk("R8 one per cycle", {16'd0, cmd_addr}, 32'h2001);
    drain();
  endtask

  task automatic t_write_drain;
    for (int i = 0; i < 6; i++) push_wr(16'h2100 + AW'(i));
    push_rd(16'h1100);
    chk("R3 mode", {30'd0, mode_o}, 32'h1);
    chk("R3 write offered", {31'd0, cmd_is_wr}, 32'h1);
    pulse();
    chk("R4 hold at 5", {30'd0, mode_o}, 32'h1);
    pulse(); pulse();
    chk("R4 hold at 3", {30'd0, mode_o}, 32'h1);
    chk("R4 still writes", {31'd0, cmd_is_wr}, 32'h1);
    chk("R9 write order", {16'd0, cmd_addr}, 32'h2103);
    pulse();
    chk("R4 exit at 2", {30'd0, mode_o}, 32'h0);
    chk("R4 read after exit", {31'd0, cmd_is_wr}, 32'h0);
    drain();
  endtask

  task automatic t_mixed;
    logic first;
    for (int i = 0; i < 3; i++) push_rd(16'h1200 + AW'(i));
    for (int i = 0; i < 3; i++) push_wr(16'h2200 + AW'(i));
    chk("R5 mode", {30'd0, mode_o}, 32'h2);
    first = cmd_is_wr;
    pulse();
    chk("R5 mode after 1", {30'd0, mode_o}, 32'h2);
    chk("R5 alternate 1", {31'd0, cmd_is_wr}, {31'd0, ~first});
    pulse();
    chk("R5 alternate 2", {31'd0, cmd_is_wr}, {31'd0, first});
    drain();
  endtask

  task automatic t_starve;
    for (int i = 0; i < 6; i++) push_wr(16'h2300 + AW'(i));
    push_rd(16'h1301);
    push_rd(16'h1302);
    repeat (8) @(negedge clk);
    chk("R6 age 9 not starved", {30'd0, mode_o}, 32'h1);
    @(negedge clk);
    chk("R6 starved mode", {30'd0, mode_o}, 32'h3);
    chk("R6 read offered", {31'd0, cmd_is_wr}, 32'h0);
    chk("R6 oldest read", {16'd0, cmd_addr}, 32'h1301);
    repeat (30) @(negedge clk);
    chk("R7 saturated age", {30'd0, mode_o}, 32'h3);
    pulse();
    chk("R6 second starved", {16'd0, cmd_addr}, 32'h1302);
    pulse();
    chk("R6 back to drain", {30'd0, mode_o}, 32'h1);
    chk("R6 write after", {31'd0, cmd_is_wr}, 32'h1);
    drain();
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) push_rd(16'h1400 + AW'(i));
    chk("R9 full ready low", {31'd0, rd_req_ready}, 32'h0);
    push_rd(16'hDEAD);
    for (int i = 0; i < 8; i++) begin
      chk("R9 order valid", {31'd0, cmd_valid}, 32'h1);
      chk("R9 order addr", {16'd0, cmd_addr}, 32'h1400 + i);
      pulse();
    end
    chk("R9 dropped push", {31'd0, cmd_valid}, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_first();
    t_write_drain();
    t_mixed();
    t_starve();
    t_full();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule